// File: doc/BRIEF.md
# HDLC Receive Deframer with Zero Deletion and FCS Check

This block sits behind a serial line receiver. It takes one line bit per strobe and looks for the 01111110 boundary pattern. Between two boundaries it drops the zero that a transmitter inserts after five ones. It packs the remaining bits into bytes, least significant bit first, and passes them out one byte at a time. Each byte is marked as start of frame and as belonging to the address field where that applies. The address field can span several bytes. Bit 0 of each byte tells whether another address byte follows.

A frame ends at the next boundary pattern. At that point the block raises a one-cycle end strobe together with a status vector. The status vector covers the frame check sequence, the length and the bit alignment. Seven ones in a row break off the current frame, and the receiver then waits for a fresh boundary pattern. The two bytes just before the closing boundary are the frame check sequence, so they are held back and never presented as data.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: After reset all outputs are low and the receiver ignores every bit until it sees a 01111110 pattern; bytes sent before that pattern produce no output.
- R2: A 01111110 pattern opens a frame and closes the one in progress; boundary patterns with no data between them produce no end strobe and no bytes.
- R3: Inside a frame, a 0 that follows five consecutive 1s is dropped from the data.
- R4: Data bytes are assembled least significant bit first; each one appears on out_data with a one-cycle out_valid pulse, and out_sof is high together with the first byte of each frame only.
- R5: out_addr is high for every byte of the address field: from the first byte up to and including the first byte whose bit 0 is 1.
- R6: The last two bytes before the closing pattern are never output; after the last data byte, fr_end pulses for one cycle on the cycle after the strobe carrying the closing pattern's final 0, never together with out_valid.
- R7: The CRC (reflected polynomial 0x8408, preset 0xFFFF, all frame bits in order) must leave a remainder of 0xF0B8; otherwise fr_err[0] is set. fr_ok is high with fr_end only when fr_err is zero, and fr_err is zero outside fr_end.
- R8: A seventh consecutive 1 inside a frame that has delivered data reports fr_end with fr_err = 4'b1000 and nothing else, and the receiver ignores bits until the next 01111110.
- R9: fr_err[2] is set when the frame's bit count is not a multiple of 8. fr_err[1] is set when no address byte has bit 0 = 1, or when the byte count is below address length + CTRL_BYTES + 2.
- R10: bit_in is only taken on cycles with bit_en high; without a strobe, out_valid and fr_end stay low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Qualifies bit_in for this cycle |
| bit_in | input | 1 | Received line bit |
| out_valid | output | 1 | One-cycle pulse: out_data holds a frame byte |
| out_data | output | 8 | Received byte |
| out_sof | output | 1 | The byte is the first of its frame |
| out_addr | output | 1 | The byte belongs to the address field |
| fr_end | output | 1 | One-cycle frame end strobe |
| fr_ok | output | 1 | Frame ended without error (with fr_end) |
| fr_err | output | 4 | [0] FCS, [1] short, [2] alignment, [3] abort |

## Verification
The hardest cases to reach are the ones where data ones touch the closing pattern or the abort run. There the closing pattern's leading bits have already been taken as data before the pattern can be recognised. The bench builds frames whose bytes are full of 0xFF, 0x7E and 0x3F, and it inserts zeros the way a transmitter would. It then drives them with random gaps between strobes, so zero deletion, the withheld bytes and the end detection all meet at byte borders. The reference model works on a plain bit queue and checks every output on every clock. It also covers misaligned frames, short frames, address fields that never terminate, and bytes sent while the receiver waits after an abort.

// File: rtl/hdlc_rx_deframer.sv
`timescale 1ns/1ps
module hdlc_rx_deframer #(
  parameter int CTRL_BYTES = 1,
  parameter int CNT_W      = 8,
  parameter int ALEN_W     = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       bit_in,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_sof,
  output logic       out_addr,
  output logic       fr_end,
  output logic       fr_ok,
  output logic [3:0] fr_err
);
  localparam int LW = ((CNT_W > ALEN_W) ? CNT_W : ALEN_W) + 2;
  localparam logic [15:0] RESIDUE = 16'hF0B8;

  logic [2:0] ones;
  logic       open_q, busy, emitted, adone, edone;
  logic [5:0] dly;
  logic [2:0] dcnt, bcnt;
  logic [6:0] sh;
  logic [15:0] crc;
  logic [7:0] h0, h1;
  logic [1:0] hv;
  logic [CNT_W-1:0] nbytes;
  logic [ALEN_W-1:0] alen;

  wire is_flag   = bit_en && !bit_in && ones == 3'd6;
  wire is_abort  = bit_en &&  bit_in && ones == 3'd6;
  wire take      = bit_en && open_q && ones < 3'd5;
  wire shift_out = take && dcnt == 3'd6;
  wire dbit      = dly[0];
  wire byte_done = shift_out && bcnt == 3'd7;
  wire [7:0] new_byte = {dbit, sh};
  wire [2:0] ones_nxt = bit_in ? ((ones == 3'd7) ? 3'd7 : ones + 3'd1) : 3'd0;
  wire [15:0] crc_nxt = {1'b0, crc[15:1]} ^ ((crc[0] ^ dbit) ? 16'h8408 : 16'h0000);

  logic [LW-1:0] need;
  logic          short_f;
  logic [3:0]    end_err;
  assign need    = LW'(alen) + LW'(CTRL_BYTES + 2);
  assign short_f = !adone || (LW'(nbytes) < need);
  assign end_err = is_abort ? 4'b1000 : {1'b0, bcnt != 3'd0, short_f, crc != RESIDUE};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ones <= '0; open_q <= 1'b0; busy <= 1'b0; emitted <= 1'b0;
      adone <= 1'b0; edone <= 1'b0; dly <= '0; dcnt <= '0; bcnt <= '0;
      sh <= '0; crc <= 16'hFFFF; h0 <= '0; h1 <= '0; hv <= '0;
      nbytes <= '0; alen <= '0;
      out_valid <= 1'b0; out_data <= '0; out_sof <= 1'b0; out_addr <= 1'b0;
      fr_end <= 1'b0; fr_ok <= 1'b0; fr_err <= '0;
    end else begin
      out_valid <= 1'b0; out_sof <= 1'b0; out_addr <= 1'b0;
      fr_end <= 1'b0; fr_ok <= 1'b0; fr_err <= '0;
      if (bit_en) ones <= ones_nxt;
      if (is_flag || is_abort) begin
        if (open_q && busy) begin
          fr_end <= 1'b1;
          fr_err <= end_err;
          fr_ok  <= end_err == 4'b0000;
        end
        open_q <= is_flag;
        dcnt <= '0; busy <= 1'b0; bcnt <= '0; crc <= 16'hFFFF; hv <= '0;
        nbytes <= '0; alen <= '0; adone <= 1'b0; edone <= 1'b0; emitted <= 1'b0;
      end else if (take) begin
        dly <= {bit_in, dly[5:1]};
        if (dcnt != 3'd6) dcnt <= dcnt + 3'd1;
        if (shift_out) begin
          busy <= 1'b1;
          crc  <= crc_nxt;
          sh   <= new_byte[7:1];
          bcnt <= bcnt + 3'd1;
        end
        if (byte_done) begin
          if (nbytes != '1) nbytes <= nbytes + 1'b1;
          if (!adone) begin
            if (alen != '1) alen <= alen + 1'b1;
            if (new_byte[0]) adone <= 1'b1;
          end
          h1 <= new_byte;
          h0 <= h1;
          if (hv != 2'd2) hv <= hv + 2'd1;
          else begin
            out_valid <= 1'b1;
            out_data  <= h0;
            out_sof   <= !emitted;
            emitted   <= 1'b1;
            out_addr  <= !edone;
            if (h0[0]) edone <= 1'b1;
          end
        end
      end
    end
  end
endmodule

module hdlc_rx_deframer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_en,
  input logic       bit_in,
  input logic       out_valid,
  input logic       out_sof,
  input logic       fr_end,
  input logic       fr_ok,
  input logic [3:0] fr_err
);
  AST_FLAG_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_end && !fr_err[3]) |-> $past(bit_en && !bit_in)); // R2
  AST_SOF_WITH_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_valid); // R4
  AST_END_APART: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && fr_end)); // R6
  AST_QUIET_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    !fr_end |-> (fr_err == 4'b0000 && !fr_ok)); // R7
  AST_ABORT_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_end && fr_err[3]) |-> ($past(bit_en && bit_in) && $countones(fr_err) == 1)); // R8
  AST_STROBE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> (!out_valid && !fr_end)); // R10
endmodule

bind hdlc_rx_deframer hdlc_rx_deframer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
  .out_valid(out_valid), .out_sof(out_sof), .fr_end(fr_end),
  .fr_ok(fr_ok), .fr_err(fr_err)
);

// File: tb/hdlc_rx_deframer_test.sv
`timescale 1ns/1ps
module hdlc_rx_deframer_test;
  localparam int CTRL = 1;
  logic clk = 1'b0, rst_n = 1'b0, bit_en = 1'b0, bit_in = 1'b0;
  logic out_valid, out_sof, out_addr, fr_end, fr_ok;
  logic [7:0] out_data;
  logic [3:0] fr_err;

  always #4 clk = ~clk;

  hdlc_rx_deframer #(.CTRL_BYTES(CTRL)) uut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
    .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
    .out_addr(out_addr), .fr_end(fr_end), .fr_ok(fr_ok), .fr_err(fr_err));

  int checks = 0, errors = 0, cyc = 0;
  string tag = "R1";
  bit gaps = 0;

  int m_ones = 0;
  bit m_open = 0;
  bit q[$];
  int nb = 0;
  bit e_valid, e_sof, e_addr, e_end, e_ok;
  logic [7:0] e_data;
  logic [3:0] e_err;
  logic [7:0] fb[$];

  function automatic logic [7:0] qbyte(int k);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = q[8*k+i];
    return r;
  endfunction

  function automatic logic [15:0] crc_step(logic [15:0] c, bit b);
    return {1'b0, c[15:1]} ^ ((c[0] ^ b) ? 16'h8408 : 16'h0000);
  endfunction

  task automatic eval_frame(int n);
    logic [15:0] c = 16'hFFFF;
    int nbytes = n / 8;
    int alen = 0;
    bit found = 0;
    bit shrt;
    for (int i = 0; i < n; i++) c = crc_step(c, q[i]);
    for (int j = 0; j < nbytes && !found; j++) begin
      alen++;
      if (qbyte(j)[0]) found = 1;
    end
    shrt = !found || (nbytes < alen + CTRL + 2);
    e_end = 1;
    e_err = {1'b0, (n % 8) != 0, shrt, c != 16'hF0B8};
    e_ok = (e_err == 4'b0000);
  endtask

  task automatic model(bit en, bit b);
    e_valid = 0; e_sof = 0; e_addr = 0; e_end = 0; e_ok = 0; e_err = 4'b0000;
    if (!en) return;
    if (!b && m_ones == 6) begin
      if (m_open && q.size() > 6) eval_frame(q.size() - 6);
      m_open = 1; q.delete(); nb = 0;
    end else if (b && m_ones == 6) begin
      if (m_open && q.size() > 6) begin e_end = 1; e_err = 4'b1000; end
      m_open = 0; q.delete(); nb = 0;
    end else if (m_open && m_ones < 5) begin
      q.push_back(b);
      if (q.size() >= 6 + 8*(nb+1)) begin
        nb++;
        if (nb >= 3) begin
          int k = nb - 3;
          e_valid = 1; e_data = qbyte(k); e_sof = (k == 0); e_addr = 1;
          for (int j = 0; j < k; j++) if (qbyte(j)[0]) e_addr = 0;
        end
      end
    end
    m_ones = b ? ((m_ones == 7) ? 7 : m_ones + 1) : 0;
  endtask

  task automatic chk(bit c, string what, int act, int exp);
    checks++;
    if (!c) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(out_valid == e_valid, "out_valid", out_valid, e_valid);
    if (e_valid) chk(out_data == e_data, "out_data", out_data, e_data);
    chk(out_sof == e_sof, "out_sof", out_sof, e_sof);
    chk(out_addr == e_addr, "out_addr", out_addr, e_addr);
    chk(fr_end == e_end, "fr_end", fr_end, e_end);
    chk(fr_err == e_err, "fr_err", fr_err, e_err);
    chk(fr_ok == e_ok, "fr_ok", fr_ok, e_ok);
  endtask

  task automatic step(bit en, bit b);
    @(negedge clk);
    compare();
    bit_en = en; bit_in = b;
    model(en, b);
  endtask

  task automatic sbit(bit b);
    if (gaps) repeat ($urandom_range(0, 2)) step(0, 0);
    step(1, b);
  endtask

  task automatic sflag();
    sbit(0); repeat (6) sbit(1); sbit(0);
  endtask

  task automatic send_frame(int corrupt, int extra, int abort_at);
    bit d[$];
    logic [15:0] c = 16'hFFFF;
    int ones = 0;
    foreach (fb[k]) for (int i = 0; i < 8; i++) d.push_back(fb[k][i]);
    repeat (extra) d.push_back(0);
    foreach (d[i]) c = crc_step(c, d[i]);
    c = ~c;
    for (int i = 0; i < 16; i++) d.push_back(c[i]);
    if (corrupt >= 0) d[corrupt] = ~d[corrupt];
    sflag();
    foreach (d[j]) begin
      if (j == abort_at) begin
        repeat (7) sbit(1);
        return;
      end
      sbit(d[j]);
      ones = d[j] ? ones + 1 : 0;
      if (ones == 5) begin sbit(0); ones = 0; end
    end
    sflag();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    e_valid = 0; e_sof = 0; e_addr = 0; e_end = 0; e_ok = 0; e_err = 0; e_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state and bits before the first boundary are ignored
    tag = "R1";
    step(0, 0);
    for (int i = 0; i < 40; i++) sbit(i % 3 == 0);
    // R2: idle boundary patterns only
    tag = "R2";
    repeat (4) sflag();
    // R3 R4 R6: stuffing-heavy payload with single address byte
    tag = "R3";
    fb = '{8'h03, 8'h10, 8'hFF, 8'hFF, 8'h7E, 8'h3F, 8'hF8};
    send_frame(-1, 0, -1);
    tag = "R4";
    fb = '{8'h01, 8'h22, 8'hA5, 8'h5A, 8'h00, 8'h81};
    send_frame(-1, 0, -1);
    // R5: multi-byte address
    tag = "R5";
    fb = '{8'h02, 8'h04, 8'h05, 8'h13, 8'hAA, 8'hFF, 8'h7E};
    send_frame(-1, 0, -1);
    // R6: minimum length frame, all bytes withheld except address and control
    tag = "R6";
    fb = '{8'h03, 8'h10};
    send_frame(-1, 0, -1);
    // R7: corrupted bit gives FCS error
    tag = "R7";
    fb = '{8'h03, 8'h10, 8'h55, 8'hFF};
    send_frame(20, 0, -1);
    // R9: misaligned and short frames, unterminated address
    tag = "R9";
    fb = '{8'h03, 8'h10, 8'h66};
    send_frame(-1, 3, -1);
    fb = '{8'h03};
    send_frame(-1, 0, -1);
    fb = '{8'h02, 8'h04, 8'h06, 8'h08};
    send_frame(-1, 0, -1);
    // R8: abort mid-frame, then bytes without a boundary are ignored
    tag = "R8";
    fb = '{8'h03, 8'h10, 8'h12, 8'h34, 8'h56, 8'h78};
    send_frame(-1, 0, 37);
    for (int i = 0; i < 30; i++) sbit(i % 4 == 1);
    fb = '{8'h03, 8'h10, 8'hC3, 8'h3C};
    send_frame(-1, 0, -1);
    // R10: random gaps between strobes
    tag = "R10";
    gaps = 1;
    fb = '{8'h00, 8'h07, 8'h11, 8'hFF, 8'hFE, 8'h7F, 8'h7E};
    send_frame(-1, 0, -1);
    fb = '{8'h03, 8'h10, 8'hEE};
    send_frame(5, 0, -1);
    gaps = 0;
    repeat (4) step(0, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule